// File: doc/BRIEF.md
# Bus-Master Descriptor DMA Engine for a Disk Channel

This block moves sector data for one disk channel between the drive's word stream and system memory without processor involvement. Software places a table of 8-byte descriptors in memory. Each descriptor names a buffer address and a byte count, and one flag marks the final descriptor. Software loads the table pointer, then sets the start bit together with a direction bit. The engine fetches descriptors one after another over a 16-bit memory port and steps through each buffer one word at a time.

The drive side is a pair of valid/ready word streams, one for each direction, plus a level flag that shows the drive has finished its part of the transfer. When the run ends, the status register records how the table length compared with the drive transfer length. If both end together, the engine stops with the interrupt set. If the table runs out first, the engine stops silently. If the drive finishes first, the engine stays active and raises the interrupt. Software can stop a run at any time by clearing the start bit.

Top module: `bmdma_engine`

## Requirements
- R1: The register port decodes offset 0 as command (bit 0 start, bit 3 set = drive-to-memory), offset 2 as status and offset 4 as the 32-bit table pointer. A run begins only when the start bit is written as 1 while the stored start bit is 0. After reset, the status reads 0 and no memory request is made.
- R2: Each descriptor is read as four 16-bit little-endian halfwords starting at the table pointer: buffer address low, buffer address high, byte count, then flags. Bit 15 of the flags halfword (bit 31 of the second 32-bit word) marks the last entry. The next descriptor lies 8 bytes further on.
- R3: In drive-to-memory mode each drive word is written to consecutive even byte addresses starting at the buffer address. In the other direction, memory words are read in address order and handed to the drive in that order.
- R4: A byte count of 0 means 65536 bytes. An odd byte count has its low bit dropped, so transfers proceed in whole 16-bit words.
- R5: If the last descriptor is used up exactly when the drive is done, status becomes 3'b100 (interrupt only) and irq is high.
- R6: If the last descriptor is used up while the drive still expects data, status becomes 3'b000 and irq stays low. No memory request is made while the status active bit (bit 0) is clear.
- R7: If the drive is done while descriptor bytes remain, status becomes 3'b101 (active and interrupt) and no further memory cycles are issued.
- R8: Writing 0 to the command register clears the active bit on the next cycle and leaves the interrupt bit as it was. A long run that is stopped therefore reads 3'b100, and a run stopped mid-transfer without an interrupt reads 3'b000.
- R9: Writing status with bit 2 set clears the interrupt bit. Writing status with bit 2 clear leaves it unchanged. irq equals status bit 2.
- R10: While busMasterEn is low, memReq stays low. The run continues once the enable returns.
- R11: Status bit 1 (error) reads 0 in every outcome.
- R12: A memory request that is not acknowledged stays asserted with the same address, unless the run is stopped or bus mastering is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busMasterEn | input | 1 | Permission to issue memory cycles |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register byte offset |
| regWrData | input | 32 | Register write data |
| statusOut | output | 3 | {interrupt, error, active} |
| irq | output | 1 | Interrupt request |
| memReq | output | 1 | Memory cycle request |
| memWe | output | 1 | Memory cycle is a write |
| memAddr | output | 32 | Memory byte address (even) |
| memWdata | output | 16 | Memory write word |
| memRdata | input | 16 | Memory read word, valid with memAck |
| memAck | input | 1 | Memory cycle completes this clock |
| drvInData | input | 16 | Word from the drive |
| drvInValid | input | 1 | Drive word available |
| drvInReady | output | 1 | Drive word taken |
| drvOutData | output | 16 | Word to the drive |
| drvOutValid | output | 1 | Word to the drive available |
| drvOutReady | input | 1 | Drive accepts the word |
| drvDone | input | 1 | Drive has finished its transfer |

## Verification
The hardest case to reach is the exact-match ending. The drive's done flag must be up in the very cycle the engine decides after the final word, so the bench's drive model raises it in the half cycle that follows the last handshake. The bench then runs the same table against a drive that wants fewer words and one that wants more, to produce the long and short endings. A zero byte count is shown to mean 65536 bytes by a drive that stops after three words: the run ends long instead of short. Stalled memory acknowledges, a withheld bus-master enable and a drive that refuses data while a stop is written cover the remaining waiting paths.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int WORD_W      = 16;
  localparam int ADDR_W      = 32;
  localparam int CNT_W       = 16;
  localparam int REG_OFF_W   = 3;
  localparam int DESC_HALVES = 4;
  localparam int IDX_W       = $clog2(DESC_HALVES);
  localparam int WORD_BYTES  = WORD_W / 8;
  localparam int DESC_BYTES  = DESC_HALVES * WORD_BYTES;

  localparam logic [REG_OFF_W-1:0] OFF_CMD = 3'd0;
  localparam logic [REG_OFF_W-1:0] OFF_STS = 3'd2;
  localparam logic [REG_OFF_W-1:0] OFF_PTR = 3'd4;

  localparam int CMD_GO_BIT    = 0;
  localparam int CMD_TOMEM_BIT = 3;
  localparam int STS_INTR_BIT  = 2;
  localparam int LAST_FLAG_BIT = WORD_W - 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_DECIDE, ST_MOVE, ST_PUSH, ST_HOLD
  } engState_t;

  typedef struct packed {
    logic             selTable;
    logic [IDX_W-1:0] idx;
    logic             descWord;
    logic             captureRd;
    logic             wordDone;
    logic             endLong;
    logic             endExact;
    logic             endShort;
  } dpStrobe_t;
endpackage

// File: rtl/bmdma_datapath.sv
module bmdma_datapath
  import bmdma_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWr,
  input  logic [REG_OFF_W-1:0] regAddr,
  input  logic [ADDR_W-1:0]    regWrData,
  input  dpStrobe_t            stb,
  input  logic [WORD_W-1:0]    memRdata,
  output logic                 startReq,
  output logic                 active,
  output logic                 dirToMem,
  output logic                 wordsZero,
  output logic                 lastEntry,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [WORD_W-1:0]    outWord,
  output logic [2:0]           status
);
  logic              cmdGo, activeQ, intrQ, dirQ, lastQ;
  logic [ADDR_W-1:0] ptrQ, tableQ, bufQ;
  logic [CNT_W-1:0]  wordsQ;
  logic [WORD_W-1:0] outQ;
  logic              cmdWr, stsWr, ptrWr, stopReq;

  assign cmdWr    = regWr && (regAddr == OFF_CMD);
  assign stsWr    = regWr && (regAddr == OFF_STS);
  assign ptrWr    = regWr && (regAddr == OFF_PTR);
  assign startReq = cmdWr && regWrData[CMD_GO_BIT] && !cmdGo && !activeQ;
  assign stopReq  = cmdWr && !regWrData[CMD_GO_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdGo <= 1'b0; activeQ <= 1'b0; intrQ <= 1'b0; dirQ <= 1'b0; lastQ <= 1'b0;
      ptrQ <= '0; tableQ <= '0; bufQ <= '0; wordsQ <= '0; outQ <= '0;
    end else begin
      if (cmdWr) cmdGo <= regWrData[CMD_GO_BIT];
      if (ptrWr) ptrQ <= regWrData;
      if (startReq) begin
        activeQ <= 1'b1;
        dirQ    <= regWrData[CMD_TOMEM_BIT];
        tableQ  <= ptrQ;
      end else if (stopReq || stb.endExact || stb.endShort) begin
        activeQ <= 1'b0;
      end
      // a completion event outranks a simultaneous clear
      if (stb.endLong || stb.endExact) intrQ <= 1'b1;
      else if (stsWr && regWrData[STS_INTR_BIT]) intrQ <= 1'b0;
      if (stb.descWord) begin
        case (stb.idx)
          2'd0: bufQ[WORD_W-1:0] <= memRdata;
          2'd1: bufQ[ADDR_W-1:WORD_W] <= memRdata[ADDR_W-WORD_W-1:0];
          2'd2: wordsQ <= (memRdata == '0) ? {1'b1, {(CNT_W-1){1'b0}}}
                                           : {1'b0, memRdata[CNT_W-1:1]};
          default: begin
            lastQ  <= memRdata[LAST_FLAG_BIT];
            tableQ <= tableQ + ADDR_W'(DESC_BYTES);
          end
        endcase
      end
      if (stb.captureRd) outQ <= memRdata;
      if (stb.wordDone) begin
        bufQ   <= bufQ + ADDR_W'(WORD_BYTES);
        wordsQ <= wordsQ - 1'b1;
      end
    end
  end

  assign active    = activeQ;
  assign dirToMem  = dirQ;
  assign wordsZero = (wordsQ == '0);
  assign lastEntry = lastQ;
  assign memAddr   = stb.selTable ? tableQ + ADDR_W'({stb.idx, 1'b0}) : bufQ;
  assign outWord   = outQ;
  assign status    = {intrQ, 1'b0, activeQ};
endmodule

// File: rtl/bmdma_control.sv
module bmdma_control
  import bmdma_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      active,
  input  logic      dirToMem,
  input  logic      wordsZero,
  input  logic      lastEntry,
  input  logic      busMasterEn,
  input  logic      drvDone,
  input  logic      drvInValid,
  input  logic      drvOutReady,
  input  logic      memAck,
  output dpStrobe_t stb,
  output logic      memReq,
  output logic      memWe,
  output logic      drvInReady,
  output logic      drvOutValid
);
  engState_t        st, stN;
  logic [IDX_W-1:0] idxQ;
  logic             memOk;

  assign memOk = active && busMasterEn;

  always_comb begin
    stN = st; stb = '0; stb.idx = idxQ;
    memReq = 1'b0; memWe = 1'b0; drvInReady = 1'b0; drvOutValid = 1'b0;
    case (st)
      ST_IDLE: if (startReq) stN = ST_FETCH;
      ST_FETCH: begin
        stb.selTable = 1'b1;
        memReq = memOk;
        if (memReq && memAck) begin
          stb.descWord = 1'b1;
          if (idxQ == IDX_W'(DESC_HALVES - 1)) stN = ST_DECIDE;
        end
      end
      ST_DECIDE: begin
        if (wordsZero) begin
          if (!lastEntry) stN = ST_FETCH;
          else if (drvDone) begin stb.endExact = 1'b1; stN = ST_IDLE; end
          else begin stb.endShort = 1'b1; stN = ST_IDLE; end
        end else if (drvDone) begin
          stb.endLong = 1'b1; stN = ST_HOLD;
        end else stN = ST_MOVE;
      end
      ST_MOVE: begin
        if (dirToMem) begin
          memReq = memOk && drvInValid;
          memWe = memReq;
          drvInReady = memReq && memAck;
          if (drvInReady) begin stb.wordDone = 1'b1; stN = ST_DECIDE; end
        end else begin
          memReq = memOk;
          if (memReq && memAck) begin stb.captureRd = 1'b1; stN = ST_PUSH; end
        end
      end
      ST_PUSH: begin
        drvOutValid = 1'b1;
        if (drvOutReady) begin stb.wordDone = 1'b1; stN = ST_DECIDE; end
      end
      ST_HOLD: stN = ST_HOLD;
      default: stN = ST_IDLE;
    endcase
    if (!active) begin
      stb = '0; stb.idx = idxQ;
      memReq = 1'b0; memWe = 1'b0; drvInReady = 1'b0; drvOutValid = 1'b0;
      stN = startReq ? ST_FETCH : ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st <= ST_IDLE; idxQ <= '0;
    end else begin
      st <= stN;
      if (!active || st == ST_DECIDE) idxQ <= '0;
      else if (stb.descWord) idxQ <= idxQ + 1'b1;
    end
  end
endmodule

// File: rtl/bmdma_engine.sv
module bmdma_engine
  import bmdma_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busMasterEn,
  input  logic                 regWr,
  input  logic [REG_OFF_W-1:0] regAddr,
  input  logic [ADDR_W-1:0]    regWrData,
  output logic [2:0]           statusOut,
  output logic                 irq,
  output logic                 memReq,
  output logic                 memWe,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [WORD_W-1:0]    memWdata,
  input  logic [WORD_W-1:0]    memRdata,
  input  logic                 memAck,
  input  logic [WORD_W-1:0]    drvInData,
  input  logic                 drvInValid,
  output logic                 drvInReady,
  output logic [WORD_W-1:0]    drvOutData,
  output logic                 drvOutValid,
  input  logic                 drvOutReady,
  input  logic                 drvDone
);
  dpStrobe_t stb;
  logic      startReq, active, dirToMem, wordsZero, lastEntry;
  logic [2:0] status;

  bmdma_datapath dp_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWrData(regWrData),
    .stb(stb), .memRdata(memRdata), .startReq(startReq), .active(active),
    .dirToMem(dirToMem), .wordsZero(wordsZero), .lastEntry(lastEntry),
    .memAddr(memAddr), .outWord(drvOutData), .status(status)
  );

  bmdma_control ctl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .active(active), .dirToMem(dirToMem),
    .wordsZero(wordsZero), .lastEntry(lastEntry), .busMasterEn(busMasterEn),
    .drvDone(drvDone), .drvInValid(drvInValid), .drvOutReady(drvOutReady),
    .memAck(memAck), .stb(stb), .memReq(memReq), .memWe(memWe),
    .drvInReady(drvInReady), .drvOutValid(drvOutValid)
  );

  assign memWdata  = drvInData;
  assign statusOut = status;
  assign irq       = status[STS_INTR_BIT];
endmodule

// File: rtl/bmdma_engine_checker.sv
module bmdma_engine_checker
  import bmdma_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 busMasterEn,
  input logic                 regWr,
  input logic [REG_OFF_W-1:0] regAddr,
  input logic                 wrGoBit,
  input logic                 wrIntrBit,
  input logic [2:0]           statusOut,
  input logic                 irq,
  input logic                 memReq,
  input logic                 memAck,
  input logic [ADDR_W-1:0]    memAddr
);
  assert_no_req_disabled_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busMasterEn |-> !memReq);

  assert_idle_no_mem_R6: assert property (@(posedge clk) disable iff (!rstN)
    !statusOut[0] |-> !memReq);

  assert_stop_clears_active_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == OFF_CMD && !wrGoBit) |=> !statusOut[0]);

  assert_zero_write_keeps_irq_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == OFF_STS && !wrIntrBit && irq) |=> irq);

  assert_req_held_R12: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && busMasterEn && !(regWr && regAddr == OFF_CMD))
      |=> (!memReq || $stable(memAddr)));
endmodule

bind bmdma_engine bmdma_engine_checker chk_i (
  .clk(clk), .rstN(rstN), .busMasterEn(busMasterEn), .regWr(regWr), .regAddr(regAddr),
  .wrGoBit(regWrData[0]), .wrIntrBit(regWrData[2]), .statusOut(statusOut), .irq(irq),
  .memReq(memReq), .memAck(memAck), .memAddr(memAddr)
);

// File: tb/bmdma_engine_tb_top.sv
module bmdma_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_AW     = 9;
  localparam int MEM_WORDS  = 1 << MEM_AW;
  localparam logic [31:0] TABLE_BASE = 32'h100;

  logic clk = 1'b0, rstN = 1'b0, busMasterEn = 1'b1, regWr = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [2:0]  statusOut;
  logic        irq, memReq, memWe, memAck, drvInReady, drvOutValid;
  logic [31:0] memAddr;
  logic [15:0] memWdata, memRdata, drvOutData;
  logic [15:0] drvInData = '0;
  logic        drvInValid = 1'b0, drvOutReady = 1'b1, drvDone = 1'b0;
  logic [15:0] mem [MEM_WORDS];
  logic        memStall = 1'b0, stallMode = 1'b0;

  int driveWords = 0, drvCnt = 0, cycleCnt = 0, checks = 0, errors = 0;
  logic toMemMode = 1'b0, armed = 1'b0;
  logic [15:0] seed = '0;
  logic [31:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign memAck   = memReq && !memStall;
  assign memRdata = mem[memAddr[MEM_AW:1]];

  bmdma_engine dut_i (
    .clk(clk), .rstN(rstN), .busMasterEn(busMasterEn), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .statusOut(statusOut), .irq(irq), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck),
    .drvInData(drvInData), .drvInValid(drvInValid), .drvInReady(drvInReady),
    .drvOutData(drvOutData), .drvOutValid(drvOutValid), .drvOutReady(drvOutReady),
    .drvDone(drvDone)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] drvWord(input int i);
    return 16'hA000 ^ (seed + 16'(i));
  endfunction

  task automatic scoreItem(input logic [31:0] item);
    if (expQ.size() == 0) chk(1'b0, "R3 unexpected item", item, 32'h0);
    else begin
      logic [31:0] e;
      e = expQ.pop_front();
      chk(e == item, "R3 scoreboard", item, e);
    end
  endtask

  // monitor and drive/memory model: apply last cycle's handshakes, then sample
  initial begin
    logic pWr, pIn, pOut;
    logic [15:0] wA, wD, oD;
    pWr = 1'b0; pIn = 1'b0; pOut = 1'b0; wA = '0; wD = '0; oD = '0;
    forever begin
      @(negedge clk);
      cycleCnt++;
      if (pWr) begin mem[wA[MEM_AW:1]] = wD; scoreItem({wA, wD}); end
      if (pIn) drvCnt++;
      if (pOut) begin scoreItem({16'hFFFF, oD}); drvCnt++; end
      drvDone    = armed && (drvCnt >= driveWords);
      drvInValid = armed && toMemMode && (drvCnt < driveWords);
      drvInData  = drvWord(drvCnt);
      memStall   = stallMode && (cycleCnt % 3 != 0);
      #1;
      pWr = memReq && memWe && memAck; wA = memAddr[15:0]; wD = memWdata;
      pIn = drvInValid && drvInReady;
      pOut = drvOutValid && drvOutReady; oD = drvOutData;
    end
  end

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic setDesc(input int slot, input logic [31:0] a, input logic [15:0] cnt, input bit last);
    int b;
    b = int'(TABLE_BASE >> 1) + slot * 4;
    mem[b] = a[15:0]; mem[b+1] = a[31:16]; mem[b+2] = cnt; mem[b+3] = last ? 16'h8000 : 16'h0;
  endtask

  task automatic arm(input bit toMem, input int words, input logic [15:0] sd);
    toMemMode = toMem; driveWords = words; seed = sd; drvCnt = 0; armed = 1'b1;
    @(negedge clk);
  endtask

  task automatic pushWrites(input logic [15:0] a, input int n);
    for (int i = 0; i < n; i++) expQ.push_back({a + 16'(2*i), drvWord(i)});
  endtask

  task automatic pushReads(input logic [15:0] a, input int n);
    for (int i = 0; i < n; i++) expQ.push_back({16'hFFFF, mem[(a >> 1) + 16'(i)]});
  endtask

  task automatic startRun(input bit toMem);
    regWrite(3'd4, TABLE_BASE);
    regWrite(3'd0, toMem ? 32'h9 : 32'h1);
  endtask

  task automatic finishRun(input string req, input logic [2:0] expSts);
    int n;
    n = 0;
    while (statusOut == 3'b001 && n < 3000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    chk(statusOut == expSts, req, 32'(statusOut), 32'(expSts));
    chk(irq == expSts[2], req, 32'(irq), 32'(expSts[2]));
    chk(expQ.size() == 0, req, expQ.size(), 0);
  endtask

  task automatic quietReqs(input int n, output int c);
    c = 0;
    repeat (n) begin @(negedge clk); if (memReq) c++; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int c;
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = 16'h5000 + 16'(i*7);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(statusOut == 3'b000, "R1 reset status", 32'(statusOut), 0);
    chk(!irq && !memReq, "R1 reset outputs", {irq, memReq}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R5 exact end, drive to memory, single descriptor (R2, R3)
    setDesc(0, 32'h10, 16'd8, 1'b1);
    arm(1'b1, 4, 16'h11);
    pushWrites(16'h10, 4);
    startRun(1'b1);
    finishRun("R5 exact to memory", 3'b100);

    // R9 interrupt clear semantics
    regWrite(3'd2, 32'h0);
    chk(statusOut == 3'b100 && irq, "R9 zero write keeps intr", {irq, statusOut}, 32'hC);
    regWrite(3'd2, 32'h4);
    chk(statusOut == 3'b000 && !irq, "R9 one clears intr", {irq, statusOut}, 32'h0);
    regWrite(3'd0, 32'h0);
    armed = 1'b0;

    // R2 two descriptors, memory to drive, exact end
    setDesc(0, 32'h40, 16'd4, 1'b0);
    setDesc(1, 32'h80, 16'd4, 1'b1);
    arm(1'b0, 4, 16'h0);
    pushReads(16'h40, 2);
    pushReads(16'h80, 2);
    startRun(1'b0);
    finishRun("R2 chained table", 3'b100);
    regWrite(3'd2, 32'h4);
    regWrite(3'd0, 32'h0);

    // R6 short table
    setDesc(0, 32'h10, 16'd4, 1'b1);
    arm(1'b1, 4, 16'h22);
    pushWrites(16'h10, 2);
    startRun(1'b1);
    finishRun("R6 short table", 3'b000);
    quietReqs(20, c);
    chk(c == 0, "R6 no memory after short end", c, 0);
    chk(drvCnt == 2, "R6 words taken from drive", drvCnt, 2);

    // R1 start bit already 1: rewriting 1 does not restart
    regWrite(3'd0, 32'h9);
    quietReqs(10, c);
    chk(statusOut == 3'b000 && c == 0, "R1 no restart without 0-to-1", {c[15:0], 13'd0, statusOut}, 0);
    regWrite(3'd0, 32'h0);
    armed = 1'b0;

    // R7 long table, then stop (R8)
    setDesc(0, 32'h60, 16'd16, 1'b1);
    arm(1'b0, 2, 16'h0);
    pushReads(16'h60, 2);
    startRun(1'b0);
    finishRun("R7 long table", 3'b101);
    chk(statusOut[1] == 1'b0, "R11 error bit clear", 32'(statusOut[1]), 0);
    quietReqs(20, c);
    chk(c == 0, "R7 no memory after drive done", c, 0);
    regWrite(3'd0, 32'h0);
    chk(statusOut == 3'b100, "R8 stop after long end", 32'(statusOut), 32'h4);
    regWrite(3'd2, 32'h4);
    armed = 1'b0;

    // R4 zero byte count means 65536 bytes
    setDesc(0, 32'h200, 16'd0, 1'b1);
    arm(1'b1, 3, 16'h33);
    pushWrites(16'h200, 3);
    startRun(1'b1);
    finishRun("R4 zero count is 64K", 3'b101);
    regWrite(3'd0, 32'h0);
    regWrite(3'd2, 32'h4);
    armed = 1'b0;

    // R4 odd byte count drops low bit
    setDesc(0, 32'h20, 16'd5, 1'b1);
    arm(1'b1, 2, 16'h44);
    pushWrites(16'h20, 2);
    startRun(1'b1);
    finishRun("R4 odd count", 3'b100);
    regWrite(3'd2, 32'h4);
    regWrite(3'd0, 32'h0);

    // R10 bus mastering withheld
    busMasterEn = 1'b0;
    setDesc(0, 32'h30, 16'd4, 1'b1);
    arm(1'b1, 2, 16'h55);
    pushWrites(16'h30, 2);
    startRun(1'b1);
    quietReqs(30, c);
    chk(c == 0, "R10 no request while disabled", c, 0);
    chk(statusOut == 3'b001, "R10 still active", 32'(statusOut), 1);
    busMasterEn = 1'b1;
    finishRun("R10 resumes when enabled", 3'b100);
    regWrite(3'd2, 32'h4);
    regWrite(3'd0, 32'h0);

    // R8 stop mid-transfer while the drive refuses data
    drvOutReady = 1'b0;
    setDesc(0, 32'h10, 16'd8, 1'b1);
    arm(1'b0, 4, 16'h0);
    startRun(1'b0);
    repeat (10) @(negedge clk);
    chk(statusOut == 3'b001, "R8 active before stop", 32'(statusOut), 1);
    regWrite(3'd0, 32'h0);
    chk(statusOut == 3'b000 && !irq, "R8 stop mid-transfer", {irq, statusOut}, 0);
    chk(!drvOutValid, "R8 drive offer withdrawn", 32'(drvOutValid), 0);
    quietReqs(10, c);
    chk(c == 0, "R8 no memory after stop", c, 0);
    drvOutReady = 1'b1;
    armed = 1'b0;
    @(negedge clk);

    // R12 stalled memory acknowledges, exact end
    stallMode = 1'b1;
    setDesc(0, 32'h50, 16'd6, 1'b1);
    arm(1'b1, 3, 16'h66);
    pushWrites(16'h50, 3);
    startRun(1'b1);
    finishRun("R12 stalled memory", 3'b100);
    stallMode = 1'b0;
    regWrite(3'd2, 32'h4);
    regWrite(3'd0, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule